// File: doc/BRIEF.md
# Repairable Return Address Stack

This block holds predicted return addresses for one hardware thread. A call pushes its return address, and a return reads the top of the stack and then pops it. The top is visible all the time as a pair: the address in the top slot and the index of that slot. Target selection logic saves this pair as a checkpoint when it predicts a return. Speculative pops are usually wrong on a squashed path, so the history logic can later hand the pair back through a restore request. In one cycle the restore moves the top pointer to the saved index and writes the saved address into that slot.

The storage is a circular buffer whose depth is fixed by a parameter. A push onto a full stack overwrites the oldest entry. A pop on an empty stack leaves everything unchanged, and the top slot keeps showing its stale value. Other repairs use the same ports as prediction. A squashed call that had pushed is undone by a single pop. A return that was predicted not taken but resolves taken is handled by one pop when it resolves. A system with several threads places one instance per thread.

Top module: `ras_stack`

## Requirements
- R1: After a synchronous active-high reset, `top_idx` is 0, `top_addr` is 0 and `empty` is 1.
- R2: A push (without restore) advances `top_idx` by one modulo DEPTH, shows the pushed address on `top_addr` the next cycle, and clears `empty`.
- R3: A pop (without restore) on a non-empty stack moves `top_idx` back by one modulo DEPTH, and `top_addr` shows the entry below the popped one.
- R4: A pop on an empty stack changes neither `top_idx`, `top_addr` nor `empty`.
- R5: When DEPTH entries are live, a push overwrites the oldest entry. After DEPTH+1 pushes, DEPTH pops return the last DEPTH addresses youngest first, and then the stack reports empty.
- R6: A restore sets `top_idx` to `restore_idx` and `top_addr` to `restore_addr` on the next cycle. It adds one live entry, saturating at DEPTH.
- R7: When restore is requested together with push or pop, the restore alone takes effect and the other request is ignored.
- R8: Push and pop are never requested in the same cycle.
- R9: The index wraps modulo DEPTH in both directions, from DEPTH-1 up to 0 and from 0 down to DEPTH-1.
- R10: Reading (`top_idx`, `top_addr`), popping, then restoring with the saved pair returns the same top. A following pop then yields the same entry it would have yielded before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Push `push_addr` |
| push_addr | input | AW | Return address to push |
| pop_en | input | 1 | Pop the top entry |
| restore_en | input | 1 | Rewind top to a checkpoint |
| restore_idx | input | $clog2(DEPTH) | Checkpoint index |
| restore_addr | input | AW | Checkpoint address written into the restored slot |
| top_addr | output | AW | Address in the top slot |
| top_idx | output | $clog2(DEPTH) | Index of the top slot |
| empty | output | 1 | No live entries |

## Verification
Two functions can collide in one cycle: a restore can arrive together with a pop or with a push, and the restore must win. The bench uses a depth of four and a pseudo-random sweep that issues restore+pop and restore+push pairs mixed with single operations. After each edge it compares the visible top index, top address and empty flag against a small reference model computed in the bench. Directed sequences cover overflow, popping an empty stack, wrap in both directions, and a full checkpoint round trip.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        RAS_IDLE    = 2'd0,
        RAS_PUSH    = 2'd1,
        RAS_POP     = 2'd2,
        RAS_RESTORE = 2'd3
    } ras_op_e;

    // Restore outranks push and pop; push and pop are exclusive by contract.
    function automatic ras_op_e ras_pick_op(input logic push, input logic pop,
                                            input logic restore);
        if (restore)   return RAS_RESTORE;
        else if (push) return RAS_PUSH;
        else if (pop)  return RAS_POP;
        else           return RAS_IDLE;
    endfunction

    function automatic int unsigned ras_wrap_inc(input int unsigned i,
                                                 input int unsigned depth);
        return (i >= depth - 1) ? 0 : i + 1;
    endfunction

    function automatic int unsigned ras_wrap_dec(input int unsigned i,
                                                 input int unsigned depth);
        return (i == 0) ? depth - 1 : i - 1;
    endfunction

endpackage

// File: rtl/ras_slots.sv
module ras_slots #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);

    logic [AW-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[g] <= '0;
            else if (wr_en && (int'(wr_idx) == g))
                slot[g] <= wr_data;
        end
    end

    assign rd_data = slot[rd_idx];

    // R6 / R2: a write request lands in the addressed slot
    p_write_lands_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> slot[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          restore,
    input  logic [IW-1:0] restore_idx,
    output logic [IW-1:0] top_idx,
    output logic          empty,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic          use_restore_data
);

    logic [IW-1:0] idx_q, idx_inc, idx_dec;
    logic [CW-1:0] cnt_q;
    logic          full;
    ras_op_e       op;

    assign op      = ras_pick_op(push, pop, restore);
    assign idx_inc = IW'(ras_wrap_inc(int'(idx_q), DEPTH));
    assign idx_dec = IW'(ras_wrap_dec(int'(idx_q), DEPTH));
    assign full    = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else begin
            unique case (op)
                RAS_PUSH: begin
                    idx_q <= idx_inc;
                    if (!full) cnt_q <= cnt_q + 1'b1;
                end
                RAS_POP: begin
                    if (cnt_q != '0) begin
                        idx_q <= idx_dec;
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                RAS_RESTORE: begin
                    idx_q <= restore_idx;
                    if (!full) cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wr_en            = (op == RAS_PUSH) || (op == RAS_RESTORE);
        use_restore_data = (op == RAS_RESTORE);
        wr_idx           = (op == RAS_RESTORE) ? restore_idx : idx_inc;
    end

    assign top_idx = idx_q;
    assign empty   = (cnt_q == '0);

    p_push_pop_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

    p_restore_idx_r6: assert property (@(posedge clk) disable iff (rst)
        restore |-> int'(restore_idx) < DEPTH);

    p_restore_moves_r6: assert property (@(posedge clk) disable iff (rst)
        restore |=> top_idx == $past(restore_idx));

    p_pop_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (pop && !restore && empty) |=> ($stable(top_idx) && empty));

    p_push_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (push && !restore) |=> (!empty &&
            int'(top_idx) == ((int'($past(top_idx)) + 1) % DEPTH)));

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= DEPTH);

endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_en,
    input  logic [AW-1:0] push_addr,
    input  logic          pop_en,
    input  logic          restore_en,
    input  logic [IW-1:0] restore_idx,
    input  logic [AW-1:0] restore_addr,
    output logic [AW-1:0] top_addr,
    output logic [IW-1:0] top_idx,
    output logic          empty
);

    logic          wr_en, use_restore_data;
    logic [IW-1:0] wr_idx;
    logic [AW-1:0] wr_data;

    ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .push             (push_en),
        .pop              (pop_en),
        .restore          (restore_en),
        .restore_idx      (restore_idx),
        .top_idx          (top_idx),
        .empty            (empty),
        .wr_en            (wr_en),
        .wr_idx           (wr_idx),
        .use_restore_data (use_restore_data)
    );

    assign wr_data = use_restore_data ? restore_addr : push_addr;

    ras_slots #(.DEPTH(DEPTH), .AW(AW)) u_slots (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (top_idx),
        .rd_data (top_addr)
    );

    p_restore_data_r7: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> top_addr == $past(restore_addr));

    p_push_data_r2: assert property (@(posedge clk) disable iff (rst)
        (push_en && !restore_en) |=> top_addr == $past(push_addr));

endmodule

// File: tb/tb_ras_stack.sv
module tb_ras_stack;

    localparam int DEPTH      = 4;
    localparam int AW         = 8;
    localparam int IW         = 2;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          push_en, pop_en, restore_en;
    logic [AW-1:0] push_addr, restore_addr;
    logic [IW-1:0] restore_idx;
    logic [AW-1:0] top_addr;
    logic [IW-1:0] top_idx;
    logic          empty;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model
    logic [AW-1:0] m_mem [DEPTH];
    int            m_idx, m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    ras_stack #(.DEPTH(DEPTH), .AW(AW)) dut (
        .clk(clk), .rst(rst),
        .push_en(push_en), .push_addr(push_addr),
        .pop_en(pop_en),
        .restore_en(restore_en), .restore_idx(restore_idx),
        .restore_addr(restore_addr),
        .top_addr(top_addr), .top_idx(top_idx), .empty(empty)
    );

    task automatic check(input string tag);
        tests++;
        if (int'(top_idx) != m_idx || top_addr != m_mem[m_idx] ||
            empty != (m_cnt == 0)) begin
            fails++;
            $display("FAIL %s: idx=%0d addr=%0h empty=%0b expected idx=%0d addr=%0h empty=%0b",
                     tag, top_idx, top_addr, empty, m_idx, m_mem[m_idx], m_cnt == 0);
        end
    endtask

    // One cycle: drive at negedge, model after posedge, sample 1 time unit later.
    task automatic step(input bit pu, input bit po, input bit rs,
                        input int ridx, input logic [AW-1:0] addr,
                        input string tag);
        @(negedge clk);
        push_en      = pu;
        pop_en       = po;
        restore_en   = rs;
        push_addr    = addr;
        restore_addr = addr ^ 8'h5A;
        restore_idx  = IW'(ridx);
        @(posedge clk);
        if (rs) begin
            m_idx = ridx;
            m_mem[ridx] = addr ^ 8'h5A;
            if (m_cnt < DEPTH) m_cnt++;
        end else if (pu) begin
            m_idx = (m_idx + 1) % DEPTH;
            m_mem[m_idx] = addr;
            if (m_cnt < DEPTH) m_cnt++;
        end else if (po) begin
            if (m_cnt > 0) begin
                m_idx = (m_idx + DEPTH - 1) % DEPTH;
                m_cnt--;
            end
        end
        #1;
        check(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] sv_addr;
        int            sv_idx;
        logic [15:0]   lfsr;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_idx = 0; m_cnt = 0;
        rst = 1'b1; push_en = 0; pop_en = 0; restore_en = 0;
        push_addr = '0; restore_addr = '0; restore_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset state");

        // R4: pop on empty
        step(0, 1, 0, 0, 8'h00, "R4 pop empty");
        step(0, 1, 0, 0, 8'h00, "R4 pop empty again");

        // R2, R9, R5: five pushes into four slots
        for (int i = 1; i <= DEPTH + 1; i++)
            step(1, 0, 0, 0, AW'(8'h10 * i), "R2 R9 R5 push/wrap/overwrite");
        // R3, R9: pop back through the wrap, then R5 empty after DEPTH pops
        for (int i = 0; i < DEPTH; i++)
            step(0, 1, 0, 0, 8'h00, "R3 R9 R5 pop");
        step(0, 1, 0, 0, 8'h00, "R4 pop after drain");

        // R10: checkpoint round trip
        step(1, 0, 0, 0, 8'hA1, "R2 push a");
        step(1, 0, 0, 0, 8'hB2, "R2 push b");
        sv_idx  = int'(top_idx);
        sv_addr = top_addr;
        step(0, 1, 0, 0, 8'h00, "R3 speculative pop");
        step(0, 0, 1, sv_idx, sv_addr ^ 8'h5A, "R10 restore checkpoint");
        tests++;
        if (int'(top_idx) != sv_idx || top_addr != sv_addr) begin
            fails++;
            $display("FAIL R10: idx=%0d addr=%0h expected idx=%0d addr=%0h",
                     top_idx, top_addr, sv_idx, sv_addr);
        end
        step(0, 1, 0, 0, 8'h00, "R10 pop after restore");
        tests++;
        if (top_addr != 8'hA1) begin
            fails++;
            $display("FAIL R10: addr=%0h expected a1", top_addr);
        end

        // R7: restore with pop, restore with push
        step(0, 1, 1, 3, 8'h33, "R7 restore beats pop");
        step(1, 0, 1, 0, 8'h44, "R7 restore beats push");

        // R6 saturation: restores with full count
        for (int i = 0; i < 6; i++)
            step(0, 0, 1, i % DEPTH, AW'(8'h60 + i), "R6 restore");

        // Sweep
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            int sel;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel  = int'(lfsr[2:0]);
            case (sel)
                0, 1: step(1, 0, 0, 0, lfsr[15:8], "R2 sweep push");
                2, 3: step(0, 1, 0, 0, lfsr[15:8], "R3 R4 sweep pop");
                4:    step(0, 0, 1, int'(lfsr[9:8]), lfsr[15:8], "R6 sweep restore");
                5:    step(0, 1, 1, int'(lfsr[9:8]), lfsr[15:8], "R7 sweep restore+pop");
                6:    step(1, 0, 1, int'(lfsr[9:8]), lfsr[15:8], "R7 sweep restore+push");
                default: step(0, 0, 0, 0, lfsr[15:8], "R8 sweep idle");
            endcase
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule